// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block is a watchdog timer driven by an 8-bit control register. It counts ticks from a slow-oscillator enable input. When the selected timeout passes without a kick, it raises a one-cycle system reset request. A kick strobe restarts the count. The counter is also held at zero while the watchdog is off and while chip reset is active.

Two kinds of register write are protected: turning the watchdog off and changing its timeout. Each takes effect only while a change-enable bit is set. That bit clears itself four clock cycles after it is written, so software must set it and then write the real value within that short window.

A static strap input sets the safety level. With the strap low, the watchdog starts off and software may turn it off through the timed sequence. With the strap high, it starts on and can never be turned off, but its timeout can still be changed through the same sequence.

Top module: `wdt_guard`

## Requirements
- R1: After chip reset the register reads 0x00 with the strap low and 0x08 with the strap high. Register bit 4 is change-enable, bit 3 is enable, and bits 2..0 are the timeout select.
- R2: Register bits 7..5 always read zero, even after a write of ones to them.
- R3: With timeout select n and the watchdog on, the reset request goes high for exactly one cycle. This happens in the cycle after the (BASE_TICKS << n)-th tick since the count last restarted with no kick in between.
- R4: After the reset request fires, counting restarts from zero, so the next request follows another full period.
- R5: A kick clears the count. A kick in the same cycle as the expiring tick suppresses the request.
- R6: While the watchdog is off, no request is made and the count is held at zero. After it is turned back on, a full period is needed.
- R7: Writing enable = 0 turns the watchdog off only if change-enable is already set at the time of the write. Otherwise enable stays 1. Writing enable = 1 always succeeds.
- R8: The timeout select changes only on a write made while change-enable is already set. Otherwise it keeps its value.
- R9: A write of 1 to change-enable makes the bit read 1 for four cycles. Writes in the four cycles after the setting write are accepted; a write in the fifth cycle is not.
- R10: With the strap high, enable cannot be cleared by any write sequence, and the timed sequence still changes the timeout.
- R11: Chip reset clears the count and restores the register reset value.
- R12: If a timeout change makes the current count reach or pass the new limit, the next tick fires the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| chipRst | input | 1 | Synchronous chip reset, active high |
| strapAlwaysOn | input | 1 | Static safety strap; 1 forces the watchdog permanently on |
| tickEn | input | 1 | One-cycle tick from the slow oscillator, already in the clk domain |
| kick | input | 1 | Restart strobe for the counter |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read value |
| rstReq | output | 1 | One-cycle system reset request |

## Verification
The hardest situation to reach is a protected write that lands exactly on the last cycle of the change-enable window, or one cycle after it. The bench writes the change-enable bit, waits a counted number of idle cycles, and then writes a new timeout. It shows acceptance after three idle cycles and rejection after four. A second hard case is shortening the timeout after the count has already passed the new limit. The bench reaches it by ticking partway through a long period and then running the timed sequence for a short one.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  // Strobes passed from the register control to the counting datapath.
  typedef struct packed {
    logic       run;    // watchdog enabled
    logic       clear;  // hold the counter at zero this cycle
    logic [2:0] presc;  // timeout select
  } wdtStrobes_t;

  localparam int SEL_W = 3;
  localparam int SEL_N = 1 << SEL_W;
endpackage

// File: rtl/wdt_ctrl.sv
`timescale 1ns/1ps
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int CHG_WINDOW = 4
) (
  input  logic        clk,
  input  logic        chipRst,
  input  logic        strapAlwaysOn,
  input  logic        kick,
  input  logic        wrEn,
  input  logic [4:0]  wrField,
  output wdtStrobes_t strobes,
  output logic [7:0]  rdData
);
  localparam int WIN_W = $clog2(CHG_WINDOW + 1);

  logic [WIN_W-1:0]  chgLeft;
  logic              enable;
  logic [SEL_W-1:0]  presc;
  logic              chgActive;

  assign chgActive = (chgLeft != '0);

  always_ff @(posedge clk) begin
    if (chipRst) begin
      chgLeft <= '0;
      enable  <= strapAlwaysOn;
      presc   <= '0;
    end else begin
      if (wrEn) begin
        chgLeft <= wrField[4] ? WIN_W'(CHG_WINDOW) : '0;
        if (wrField[3]) begin
          enable <= 1'b1;
        end else if (chgActive && !strapAlwaysOn) begin
          enable <= 1'b0;
        end
        if (chgActive) begin
          presc <= wrField[2:0];
        end
      end else if (chgActive) begin
        chgLeft <= chgLeft - 1'b1;
      end
      if (strapAlwaysOn) begin
        enable <= 1'b1;
      end
    end
  end

  assign strobes.run   = enable;
  assign strobes.clear = kick | ~enable;
  assign strobes.presc = presc;
  assign rdData        = {3'b000, chgActive, enable, presc};
endmodule

// File: rtl/wdt_count.sv
`timescale 1ns/1ps
module wdt_count
  import wdt_pkg::*;
#(
  parameter int BASE_TICKS = 16,
  parameter int CNT_W      = 12
) (
  input  logic        clk,
  input  logic        chipRst,
  input  logic        tickEn,
  input  wdtStrobes_t strobes,
  output logic        rstReq
);
  logic [CNT_W-1:0] limTab [SEL_N];
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] limit;

  for (genvar g = 0; g < SEL_N; g++) begin : g_lim
    assign limTab[g] = CNT_W'(BASE_TICKS) << g;
  end

  assign limit = limTab[strobes.presc];

  always_ff @(posedge clk) begin
    if (chipRst) begin
      count  <= '0;
      rstReq <= 1'b0;
    end else begin
      rstReq <= 1'b0;
      if (strobes.clear) begin
        count <= '0;
      end else if (strobes.run && tickEn) begin
        if (count >= limit - 1'b1) begin
          count  <= '0;
          rstReq <= 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdt_guard.sv
`timescale 1ns/1ps
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int BASE_TICKS = 16,
  parameter int CHG_WINDOW = 4
) (
  input  logic       clk,
  input  logic       chipRst,
  input  logic       strapAlwaysOn,
  input  logic       tickEn,
  input  logic       kick,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       rstReq
);
  localparam int CNT_W = $clog2(BASE_TICKS) + SEL_N;

  wdtStrobes_t strobes;
  wire unusedHiBits = ^wrData[7:5];

  wdt_ctrl #(.CHG_WINDOW(CHG_WINDOW)) u_ctrl (
    .clk          (clk),
    .chipRst      (chipRst),
    .strapAlwaysOn(strapAlwaysOn),
    .kick         (kick),
    .wrEn         (wrEn),
    .wrField      (wrData[4:0]),
    .strobes      (strobes),
    .rdData       (rdData)
  );

  wdt_count #(.BASE_TICKS(BASE_TICKS), .CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .chipRst(chipRst),
    .tickEn (tickEn),
    .strobes(strobes),
    .rstReq (rstReq)
  );
endmodule

// File: rtl/wdt_guard_chk.sv
`timescale 1ns/1ps
module wdt_guard_chk (
  input logic       clk,
  input logic       chipRst,
  input logic       strapAlwaysOn,
  input logic       tickEn,
  input logic       kick,
  input logic [7:0] rdData,
  input logic       rstReq
);
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (chipRst)
    rstReq |=> !rstReq);

  p_req_after_tick_r3: assert property (@(posedge clk) disable iff (chipRst)
    rstReq |-> $past(tickEn));

  p_kick_blocks_r5: assert property (@(posedge clk) disable iff (chipRst)
    kick |=> !rstReq);

  p_off_silent_r6: assert property (@(posedge clk) disable iff (chipRst)
    !rdData[3] |=> !rstReq);

  p_en_clear_guard_r7: assert property (@(posedge clk) disable iff (chipRst)
    ($fell(rdData[3]) && !$past(chipRst)) |-> $past(rdData[4]));

  p_presc_guard_r8: assert property (@(posedge clk) disable iff (chipRst)
    ((rdData[2:0] != $past(rdData[2:0])) && !$past(chipRst)) |-> $past(rdData[4]));

  p_strap_on_r10: assert property (@(posedge clk) disable iff (chipRst)
    strapAlwaysOn |-> rdData[3]);
endmodule

bind wdt_guard wdt_guard_chk u_chk (
  .clk          (clk),
  .chipRst      (chipRst),
  .strapAlwaysOn(strapAlwaysOn),
  .tickEn       (tickEn),
  .kick         (kick),
  .rdData       (rdData),
  .rstReq       (rstReq)
);

// File: tb/wdt_guard_test.sv
`timescale 1ns/1ps
module wdt_guard_test;
  localparam int BASE = 2;

  logic       clk = 1'b0;
  logic       chipRst = 1'b1;
  logic       strapAlwaysOn = 1'b0;
  logic       tickEn = 1'b0;
  logic       kick = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       rstReq;

  int checks = 0;
  int errors = 0;
  int pulses, firstAt, stuck;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdt_guard #(.BASE_TICKS(BASE), .CHG_WINDOW(4)) uut (
    .clk(clk), .chipRst(chipRst), .strapAlwaysOn(strapAlwaysOn),
    .tickEn(tickEn), .kick(kick), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .rstReq(rstReq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    chipRst = 1'b1;
    idle(2);
    chipRst = 1'b0;
  endtask

  task automatic write(input logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = 8'h00;
  endtask

  task automatic doKick();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  // Timed sequence: open the window, then write the value.
  task automatic guarded(input logic [7:0] d);
    write(8'h10);
    write(d);
  endtask

  task automatic runTicks(input int n);
    pulses = 0; firstAt = 0;
    for (int i = 1; i <= n; i++) begin
      if (rstReq) stuck++;
      tickEn = 1'b1;
      @(negedge clk);
      tickEn = 1'b0;
      if (rstReq) begin
        pulses++;
        if (firstAt == 0) firstAt = i;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    stuck = 0;
    idle(3);
    chipRst = 1'b0;

    // R1 reset value, strap low
    check("R1 reset value strap low", rdData, 8'h00);
    check("R1 no request at reset", rstReq, 0);

    // R2 reserved bits
    write(8'hE8);
    check("R2 reserved bits zero", rdData, 8'h08);
    doReset();

    // R3/R4/R8 sweep over every timeout select
    for (int n = 0; n < 8; n++) begin
      int lim;
      lim = BASE << n;
      doReset();
      guarded(8'(8'h08 | n));
      check($sformatf("R8 select %0d accepted", n), rdData, 8'h08 | n);
      runTicks(2 * lim);
      check($sformatf("R3 first request tick sel %0d", n), firstAt, lim);
      check($sformatf("R4 restart two requests sel %0d", n), pulses, 2);
    end
    check("R3 request one cycle wide", stuck, 0);

    // R5 kick clears count
    doReset();
    guarded(8'h0A);
    runTicks(5);
    doKick();
    runTicks(8);
    check("R5 kick restarts period", firstAt, 8);
    runTicks(7);
    kick = 1'b1; tickEn = 1'b1;
    @(negedge clk);
    kick = 1'b0; tickEn = 1'b0;
    check("R5 kick beats expiry", rstReq, 0);
    @(negedge clk);
    runTicks(8);
    check("R5 full period after same-cycle kick", firstAt, 8);

    // R7 protected disable
    write(8'h00);
    check("R7 unguarded disable ignored", rdData, 8'h0A);
    runTicks(8);
    check("R7 still running", pulses, 1);
    guarded(8'h02);
    check("R7 guarded disable", rdData, 8'h02);

    // R6 disabled: silent and count held
    runTicks(40);
    check("R6 no request when off", pulses, 0);
    guarded(8'h0A);
    runTicks(6);
    guarded(8'h02);
    runTicks(3);
    write(8'h0A);
    check("R6 enable without window", rdData, 8'h0A);
    runTicks(8);
    check("R6 count cleared while off", firstAt, 8);

    // R8 unguarded select change ignored
    write(8'h0F);
    check("R8 unguarded select ignored", rdData, 8'h0A);

    // R9 window length
    write(8'h10);
    check("R9 change-enable set", rdData, 8'h1A);
    idle(3);
    check("R9 change-enable held", rdData, 8'h1A);
    idle(1);
    check("R9 change-enable self-cleared", rdData, 8'h0A);
    write(8'h10);
    idle(3);
    write(8'h0D);
    check("R9 write in last window cycle accepted", rdData, 8'h0D);
    write(8'h10);
    idle(4);
    write(8'h09);
    check("R9 write after window rejected", rdData, 8'h0D);

    // R12 shrink below current count
    guarded(8'h0B);
    runTicks(10);
    guarded(8'h09);
    runTicks(5);
    check("R12 immediate expiry after shrink", firstAt, 1);
    check("R12 then regular period", pulses, 2);

    // R11 chip reset mid count
    guarded(8'h0A);
    runTicks(6);
    doReset();
    check("R11 register restored", rdData, 8'h00);
    guarded(8'h0A);
    runTicks(8);
    check("R11 count cleared by reset", firstAt, 8);

    // R10 strap forces on
    strapAlwaysOn = 1'b1;
    doReset();
    check("R1 reset value strap high", rdData, 8'h08);
    write(8'h00);
    check("R10 plain disable ignored", rdData, 8'h08);
    guarded(8'h00);
    check("R10 guarded disable ignored", rdData, 8'h08);
    guarded(8'h03);
    check("R10 guarded select change", rdData, 8'h0B);
    runTicks(32);
    check("R10 runs with new select", firstAt, 16);
    strapAlwaysOn = 1'b0;
    doReset();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule